// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational integer unit for a simple scalar pipeline. It takes two operands and a 4-bit operation code that instruction decode has already produced. In the same cycle it returns a result word, a carry flag and an overflow flag. It handles addition and subtraction in signed and unsigned variants, four bitwise functions, and signed and unsigned "set if less than" comparisons.

The datapath is a chain of one-bit slices. Each slice forms the sum and the bitwise functions for its own bit position. A small decoder turns the operation code into slice controls: a B-invert, the chain carry-in, and a result selector. A final stage picks the result and derives the flags from the carries around the top slice. Subtraction and both comparisons use the same adder, with B inverted and the carry-in forced high. Callers sign-extend or zero-extend immediates before they reach the operands.

Top module: `alu32_core`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give result = A + B modulo 2^W, and the carry flag equals the carry out of the top bit of that sum.
- R2: Codes 0010 (signed subtract) and 0011 (unsigned subtract) give result = A + ~B + 1 modulo 2^W, and the carry flag equals the carry out of the top bit of that sum. The carry is therefore 1 exactly when A >= B as unsigned values.
- R3: For codes 0000 and 0010, the overflow flag is set exactly when the carry into the top bit differs from the carry out of it. Equivalently, it is set when the true signed result does not fit in W bits.
- R4: Codes 0001, 0011 and 1011 never set the overflow flag.
- R5: Code 0100 gives A AND B, 0101 gives A OR B, 0110 gives A XOR B, and 0111 gives the inverse of A OR B.
- R6: For the four bitwise codes 0100 to 0111, both carry and overflow are 0.
- R7: Code 1010 gives a result whose bit 0 is 1 when A < B as two's complement values, and whose bits W-1..1 are all zero.
- R8: Code 1011 gives a result whose bit 0 is 1 when A < B as unsigned values, and whose bits W-1..1 are all zero.
- R9: For codes 1010 and 1011, the carry flag is the carry out of A + ~B + 1. The overflow flag is the subtraction overflow for 1010 and is 0 for 1011.
- R10: Any other code (1000, 1001, 1100 to 1111) gives a zero result with carry and overflow both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W (32) | First operand |
| opd_b | input | W (32) | Second operand |
| op_code | input | 4 | Decoded operation code |
| res_o | output | W (32) | Result word |
| carry_o | output | 1 | Carry out of the top bit for adder-based codes |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The in-design checks assume that operands and the operation code are stable, known values by the time the combinational logic has settled. They also assume no X or Z reaches the inputs. The bench changes inputs only at one point in each clock period and reads the outputs a few nanoseconds later. It drives only defined values, including every unused code, so each check sees a settled, fully known input set.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    localparam logic [3:0] OP_ADD   = 4'b0000;
    localparam logic [3:0] OP_ADDU  = 4'b0001;
    localparam logic [3:0] OP_SUB   = 4'b0010;
    localparam logic [3:0] OP_SUBU  = 4'b0011;
    localparam logic [3:0] OP_AND   = 4'b0100;
    localparam logic [3:0] OP_OR    = 4'b0101;
    localparam logic [3:0] OP_XOR   = 4'b0110;
    localparam logic [3:0] OP_NOR   = 4'b0111;
    localparam logic [3:0] OP_SLT   = 4'b1010;
    localparam logic [3:0] OP_SLTU  = 4'b1011;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_SUM,
        SEL_AND,
        SEL_OR,
        SEL_XOR,
        SEL_NOR,
        SEL_SLT,
        SEL_SLTU
    } sel_e;

    typedef struct packed {
        logic inv_b;    // feed ~B into the adder
        logic cin;      // carry into bit 0
        logic sgn;      // signed variant: overflow allowed
        logic arith;    // carry flag reported
        sel_e sel;
    } ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu32_pkg::*;
(
    input  logic [3:0] op_code,
    output ctl_t       ctl_o
);

    ctl_t ctl_d;

    always_comb begin
        ctl_d = '{inv_b: 1'b0, cin: 1'b0, sgn: 1'b0, arith: 1'b0, sel: SEL_ZERO};
        case (op_code)
            OP_ADD:  ctl_d = '{inv_b: 1'b0, cin: 1'b0, sgn: 1'b1, arith: 1'b1, sel: SEL_SUM};
            OP_ADDU: ctl_d = '{inv_b: 1'b0, cin: 1'b0, sgn: 1'b0, arith: 1'b1, sel: SEL_SUM};
            OP_SUB:  ctl_d = '{inv_b: 1'b1, cin: 1'b1, sgn: 1'b1, arith: 1'b1, sel: SEL_SUM};
            OP_SUBU: ctl_d = '{inv_b: 1'b1, cin: 1'b1, sgn: 1'b0, arith: 1'b1, sel: SEL_SUM};
            OP_AND:  ctl_d.sel = SEL_AND;
            OP_OR:   ctl_d.sel = SEL_OR;
            OP_XOR:  ctl_d.sel = SEL_XOR;
            OP_NOR:  ctl_d.sel = SEL_NOR;
            OP_SLT:  ctl_d = '{inv_b: 1'b1, cin: 1'b1, sgn: 1'b1, arith: 1'b1, sel: SEL_SLT};
            OP_SLTU: ctl_d = '{inv_b: 1'b1, cin: 1'b1, sgn: 1'b0, arith: 1'b1, sel: SEL_SLTU};
            default: ctl_d = '{inv_b: 1'b0, cin: 1'b0, sgn: 1'b0, arith: 1'b0, sel: SEL_ZERO};
        endcase
    end

    assign ctl_o = ctl_d;

    // an invert of B without the +1 would not be a subtract
    always_comb begin
        assert_sub_cin_R2: assert (ctl_d.inv_b == ctl_d.cin || op_code[3:2] == 2'b01)
            else $error("invert and carry-in disagree for code %b", op_code);
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic inv_b,
    input  logic cin,
    output logic sum_o,
    output logic cout,
    output logic and_o,
    output logic or_o,
    output logic xor_o
);

    logic bx_d;
    logic gen_d;
    logic prop_d;

    always_comb begin
        bx_d   = b_i ^ inv_b;
        gen_d  = a_i & bx_d;
        prop_d = a_i ^ bx_d;
        sum_o  = prop_d ^ cin;
        cout   = gen_d | (prop_d & cin);
        and_o  = a_i & b_i;
        or_o   = a_i | b_i;
        xor_o  = a_i ^ b_i;
    end

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  ctl_t         ctl_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    input  logic [W-1:0] xor_i,
    input  logic         c_top_in,
    input  logic         c_top_out,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         carry;
        logic         ovf;
    } out_t;

    out_t out_d;
    logic raw_ovf_d;
    logic lt_s_d;
    logic lt_u_d;

    always_comb begin
        raw_ovf_d = c_top_in ^ c_top_out;
        lt_s_d    = sum_i[W-1] ^ raw_ovf_d;
        lt_u_d    = ~c_top_out;
        out_d     = '0;
        case (ctl_i.sel)
            SEL_SUM:  out_d.res = sum_i;
            SEL_AND:  out_d.res = and_i;
            SEL_OR:   out_d.res = or_i;
            SEL_XOR:  out_d.res = xor_i;
            SEL_NOR:  out_d.res = ~or_i;
            SEL_SLT:  out_d.res = {{(W-1){1'b0}}, lt_s_d};
            SEL_SLTU: out_d.res = {{(W-1){1'b0}}, lt_u_d};
            default:  out_d.res = '0;
        endcase
        out_d.carry = ctl_i.arith & c_top_out;
        out_d.ovf   = ctl_i.arith & ctl_i.sgn & raw_ovf_d;
    end

    assign res_o   = out_d.res;
    assign carry_o = out_d.carry;
    assign ovf_o   = out_d.ovf;

endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic [3:0]   op_code,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);

    localparam int TOP = W - 1;

    ctl_t       ctl;
    logic [W:0] chain;
    logic [W-1:0] sum_v;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] xor_v;

    alu_op_decode u_dec (
        .op_code (op_code),
        .ctl_o   (ctl)
    );

    assign chain[0] = ctl.cin;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bit_slice u_bit (
            .a_i   (opd_a[i]),
            .b_i   (opd_b[i]),
            .inv_b (ctl.inv_b),
            .cin   (chain[i]),
            .sum_o (sum_v[i]),
            .cout  (chain[i+1]),
            .and_o (and_v[i]),
            .or_o  (or_v[i]),
            .xor_o (xor_v[i])
        );
    end

    alu_result_sel #(.W(W)) u_sel (
        .ctl_i     (ctl),
        .sum_i     (sum_v),
        .and_i     (and_v),
        .or_i      (or_v),
        .xor_i     (xor_v),
        .c_top_in  (chain[TOP]),
        .c_top_out (chain[W]),
        .res_o     (res_o),
        .carry_o   (carry_o),
        .ovf_o     (ovf_o)
    );

    always_comb begin
        // signed add overflows only when like-signed operands give an unlike-signed sum
        if (op_code == OP_ADD && ovf_o) begin
            assert_add_ovf_signs_R3: assert (opd_a[TOP] == opd_b[TOP] && res_o[TOP] != opd_a[TOP])
                else $error("add overflow with inconsistent signs");
        end
        if (op_code == OP_ADDU || op_code == OP_SUBU || op_code == OP_SLTU) begin
            assert_no_overflow_R4: assert (!ovf_o)
                else $error("unsigned code %b raised overflow", op_code);
        end
        if (op_code[3:2] == 2'b01) begin
            assert_logic_flags_R6: assert (!carry_o && !ovf_o)
                else $error("bitwise code %b raised a flag", op_code);
        end
        if (op_code == OP_SLT || op_code == OP_SLTU) begin
            assert_slt_upper_zero_R7: assert (res_o[TOP:1] == '0)
                else $error("compare result has upper bits set");
        end
        if (op_code[3:1] == 3'b100 || op_code[3:2] == 2'b11) begin
            assert_unused_quiet_R10: assert (res_o == '0 && !carry_o && !ovf_o)
                else $error("unused code %b produced output", op_code);
        end
    end

endmodule

// File: tb/sim_alu32_core.sv
module sim_alu32_core;

    logic        clk = 1'b0;
    logic [31:0] opd_a = '0;
    logic [31:0] opd_b = '0;
    logic [3:0]  op_code = 4'b0000;
    logic [31:0] res_o;
    logic        carry_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu32_core #(.W(32)) u0 (
        .opd_a   (opd_a),
        .opd_b   (opd_b),
        .op_code (op_code),
        .res_o   (res_o),
        .carry_o (carry_o),
        .ovf_o   (ovf_o)
    );

    // expected {res, carry, ovf}
    function automatic logic [33:0] model(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] t;
        logic [31:0] r;
        logic c;
        logic v;
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'b0000, 4'b0001: begin
                t = {1'b0, a} + {1'b0, b};
                r = t[31:0]; c = t[32];
                v = (m == 4'b0000) && (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'b0010, 4'b0011, 4'b1010, 4'b1011: begin
                t = {1'b0, a} + {1'b0, ~b} + 33'd1;
                c = t[32];
                v = (a[31] != b[31]) && (t[31] != a[31]);
                if (m == 4'b0011 || m == 4'b1011) v = 1'b0;
                if (m[3] == 1'b0) r = t[31:0];
                else if (m == 4'b1010) r = {31'd0, ($signed(a) < $signed(b))};
                else r = {31'd0, (a < b)};
            end
            4'b0100: r = a & b;
            4'b0101: r = a | b;
            4'b0110: r = a ^ b;
            4'b0111: r = ~(a | b);
            default: r = '0;
        endcase
        return {r, c, v};
    endfunction

    function automatic string res_tag(input logic [3:0] m);
        case (m)
            4'b0000, 4'b0001: return "R1";
            4'b0010, 4'b0011: return "R2";
            4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R5";
            4'b1010: return "R7";
            4'b1011: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string flag_tag(input logic [3:0] m);
        case (m)
            4'b0000, 4'b0010: return "R3";
            4'b0001, 4'b0011: return "R4";
            4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R6";
            4'b1010, 4'b1011: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic run_one(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b);
        logic [33:0] e;
        @(posedge clk);
        #1;
        op_code = m; opd_a = a; opd_b = b;
        #3;
        e = model(m, a, b);
        total++;
        if (res_o !== e[33:2]) begin
            bad++;
            $display("FAIL %s code=%b a=%h b=%h result actual=%h expected=%h",
                     res_tag(m), m, a, b, res_o, e[33:2]);
        end
        total++;
        if ({carry_o, ovf_o} !== e[1:0]) begin
            bad++;
            $display("FAIL %s code=%b a=%h b=%h flags(c,v) actual=%b%b expected=%b",
                     flag_tag(m), m, a, b, carry_o, ovf_o, e[1:0]);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [8];
        process::self().srandom(32'd152);
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'h7fff_ffff; corner[3] = 32'h8000_0000;
        corner[4] = 32'hffff_ffff; corner[5] = 32'hffff_fff7;
        corner[6] = 32'h8000_0001; corner[7] = 32'h5555_aaaa;

        // idle inputs: zero add gives zero with no flags (R1)
        #2;
        total++;
        if (res_o !== 32'd0 || carry_o !== 1'b0 || ovf_o !== 1'b0) begin
            bad++;
            $display("FAIL R1 idle state actual=%h/%b%b expected=0/00", res_o, carry_o, ovf_o);
        end

        // directed: R3 overflow both directions, R2 borrow, R7/R8 sign-sensitive compares
        run_one(4'b0000, 32'h7fff_ffff, 32'h0000_0001);
        run_one(4'b0000, 32'h8000_0000, 32'h8000_0000);
        run_one(4'b0001, 32'h7fff_ffff, 32'h0000_0001);
        run_one(4'b0010, 32'h8000_0000, 32'h0000_0001);
        run_one(4'b0010, 32'h0000_0003, 32'h0000_0005);
        run_one(4'b0011, 32'h8000_0000, 32'h0000_0001);
        run_one(4'b1010, 32'h8000_0000, 32'h0000_0001);
        run_one(4'b1011, 32'h8000_0000, 32'h0000_0001);
        run_one(4'b1010, 32'h7fff_ffff, 32'h8000_0000);
        run_one(4'b1010, 32'h1234_5678, 32'h1234_5678);
        run_one(4'b1011, 32'hffff_fff7, 32'hffff_ffff);

        // every code against every corner pair
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_one(m[3:0], corner[i], corner[j]);

        // random operands, all codes
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 7 == 0) rb = ra;
            if (k % 11 == 0) rb = ra ^ 32'h8000_0000;
            run_one(4'(k % 16), ra, rb);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule